// File: doc/BRIEF.md
# Amplifier Gate-Bias Power Sequencer

This block orders the power-up and power-down of an RF power amplifier's gate-bias path and drain supply. It watches four digital status inputs: a supply-good flag for the bias circuitry, a done handshake from a table loader, an externally generated drive-enable, and an alarm. It drives four registered controls. The first is a load request to the table loader. The second selects the clamp mode: either following the negative rail or holding the loaded pinch-off value. The third selects the bias output source, clamp or DAC. The fourth is an active-high amplifier enable that switches the drain supply.

The sequencing enforces a few safety rules. The gate sits at pinch-off whenever the drain supply may be live. The drain supply comes up only after the table has been loaded. The gate moves to the DAC only once the amplifier is enabled and the external drive-enable asks for it. On an alarm or a supply loss, the gate is pulled back to the clamp at once. The drain supply is then dropped a programmable number of cycles later, and only after that does the clamp return to following the negative rail. A restart needs the supply-good flag to drop, then return, with the alarm clear.

Top module: `pa_bias_seq`

## Requirements
- R1: While `rst_n` is low, and right after reset, the outputs are `load_req`=0, `clamp_hold`=0 (clamp follows the negative rail), `bias_on_dac`=0 (bias from clamp) and `amp_en`=0.
- R2: In the ramp state, a clock edge that samples `supply_ok`=1 with `alarm`=0 sets `load_req`=1 and `clamp_hold`=1. Both stay set until the load finishes, and `amp_en` stays 0 all that time.
- R3: The edge that samples `load_done`=1 during the load clears `load_req`, leaving `clamp_hold`=1. The next edge sets `amp_en`=1, with the bias still on the clamp.
- R4: `bias_on_dac` goes to 1 on the edge that samples `drive_en`=1 in a cycle where `amp_en` is already 1. A `drive_en` seen before then has no effect. `bias_on_dac`=1 always comes with `amp_en`=1 and `clamp_hold`=1.
- R5: While on the DAC, an edge that samples `drive_en`=0 returns the bias to the clamp and keeps `amp_en`=1.
- R6: Past the ramp state, an edge that samples `alarm`=1 or `supply_ok`=0 sets `bias_on_dac`=0 on that same edge and starts shutdown. The alarm overrides `load_done` and `drive_en`, and later `drive_en` activity has no effect.
- R7: During shutdown, `amp_en` holds its value for exactly `HOLD_CYCLES` edges after the bias reaches the clamp, then falls. `clamp_hold` stays 1 until then. `amp_en` never falls while the bias is on the DAC.
- R8: One edge after `amp_en` falls in shutdown, `clamp_hold` returns to 0 (rail tracking).
- R9: The block leaves rail tracking only on an edge that samples `supply_ok`=1 and `alarm`=0, after `supply_ok`=0 has been sampled at some edge since shutdown began. It then returns to the ramp state, and the next such edge starts a new load.
- R10: An alarm during the table load ends the load (`load_req`=0) and runs the shutdown without `amp_en` ever rising.
- R11: `HOLD_CYCLES` below 1 is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Bias supplies are within their operating range |
| load_done | input | 1 | Table loader has finished loading the clamp and DAC values |
| drive_en | input | 1 | External request to move the gate bias to the DAC |
| alarm | input | 1 | Fault input that forces shutdown |
| load_req | output | 1 | Request to the table loader |
| clamp_hold | output | 1 | 1: clamp holds the loaded pinch-off value; 0: clamp follows the negative rail |
| bias_on_dac | output | 1 | 1: bias output taken from the DAC; 0: taken from the clamp |
| amp_en | output | 1 | Active-high amplifier enable that gates the drain supply |

## Verification
The embedded properties check the ordering interlocks on every cycle:
- the DAC is never selected without the amplifier enable and the held clamp;
- the enable never rises away from the clamp and never falls straight from the DAC;
- a fault clears the DAC select on the next edge;
- no load request overlaps the enable;
- leaving rail tracking follows a good supply with no alarm.

The exact cycle counts need the bench's scenarios: the single ready cycle before the enable, the `HOLD_CYCLES` delay before the enable falls, and the one-edge step back to rail tracking. So do the fall-and-rise condition for restart, the alarm overriding a pending load-done, and a drive-enable that arrives early.

// File: rtl/pa_bias_pkg.sv
package pa_bias_pkg;

   typedef enum logic [2:0] {
      ST_RAMP     = 3'd0,
      ST_LOAD     = 3'd1,
      ST_READY    = 3'd2,
      ST_PA_CLAMP = 3'd3,
      ST_DRIVE    = 3'd4,
      ST_SD_CLAMP = 3'd5,
      ST_SD_PAOFF = 3'd6,
      ST_SD_TRACK = 3'd7
   } seq_state_e;

   typedef struct packed {
      logic load_req;
      logic clamp_hold;
      logic bias_on_dac;
      logic amp_en;
   } seq_ctrl_t;

endpackage

// File: rtl/pa_bias_hold_timer.sv
module pa_bias_hold_timer #(
   parameter int HOLD_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic done
);
   localparam int CW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

   logic [CW-1:0] cnt_q;

   assign done = run && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (!run)    cnt_q <= '0;
      else if (!done)   cnt_q <= cnt_q + CW'(1);
   end

   // The counter never passes its terminal value while the window is open (R7)
   assert_cnt_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

endmodule

// File: rtl/pa_bias_fsm.sv
module pa_bias_fsm
   import pa_bias_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       supply_ok,
   input  logic       load_done,
   input  logic       drive_en,
   input  logic       alarm,
   input  logic       hold_done,
   output seq_state_e state,
   output seq_state_e next_state
);
   logic fault;
   logic low_seen_q;
   logic in_shutdown;

   assign fault       = alarm || !supply_ok;
   assign in_shutdown = (state == ST_SD_CLAMP) || (state == ST_SD_PAOFF) ||
                        (state == ST_SD_TRACK);

   always_comb begin
      next_state = state;
      unique case (state)
         ST_RAMP:     if (supply_ok && !alarm) next_state = ST_LOAD;
         ST_LOAD:     if (fault) next_state = ST_SD_CLAMP;
                      else if (load_done) next_state = ST_READY;
         ST_READY:    if (fault) next_state = ST_SD_CLAMP;
                      else next_state = ST_PA_CLAMP;
         ST_PA_CLAMP: if (fault) next_state = ST_SD_CLAMP;
                      else if (drive_en) next_state = ST_DRIVE;
         ST_DRIVE:    if (fault) next_state = ST_SD_CLAMP;
                      else if (!drive_en) next_state = ST_PA_CLAMP;
         ST_SD_CLAMP: if (hold_done) next_state = ST_SD_PAOFF;
         ST_SD_PAOFF: next_state = ST_SD_TRACK;
         ST_SD_TRACK: if (low_seen_q && supply_ok && !alarm) next_state = ST_RAMP;
         default:     next_state = ST_RAMP;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_RAMP;
         low_seen_q <= 1'b0;
      end else begin
         state <= next_state;
         if (!in_shutdown)    low_seen_q <= 1'b0;
         else if (!supply_ok) low_seen_q <= 1'b1;
      end
   end

   // Drain switch-off step only follows the clamp hold window (R7)
   assert_paoff_after_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SD_PAOFF) |-> ($past(state) == ST_SD_CLAMP));

   // Restart out of tracking only on good supply and clear alarm (R9)
   assert_restart_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == ST_RAMP) && ($past(state) == ST_SD_TRACK)) |->
         ($past(supply_ok) && !$past(alarm)));

   // A fault outside ramp and shutdown always leads into shutdown (R6)
   assert_fault_enters_sd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fault && !in_shutdown && (state != ST_RAMP)) |=> (state == ST_SD_CLAMP));

endmodule

// File: rtl/pa_bias_outreg.sv
module pa_bias_outreg
   import pa_bias_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  seq_state_e next_state,
   output seq_ctrl_t  ctrl
);
   seq_ctrl_t ctrl_d;

   always_comb begin
      ctrl_d = '0;
      unique case (next_state)
         ST_RAMP, ST_SD_TRACK: ctrl_d = '0;
         ST_LOAD:     begin ctrl_d.load_req = 1'b1; ctrl_d.clamp_hold = 1'b1; end
         ST_READY:    ctrl_d.clamp_hold = 1'b1;
         ST_PA_CLAMP: begin ctrl_d.clamp_hold = 1'b1; ctrl_d.amp_en = 1'b1; end
         ST_DRIVE:    begin
            ctrl_d.clamp_hold  = 1'b1;
            ctrl_d.bias_on_dac = 1'b1;
            ctrl_d.amp_en      = 1'b1;
         end
         ST_SD_CLAMP: begin ctrl_d.clamp_hold = 1'b1; ctrl_d.amp_en = ctrl.amp_en; end
         ST_SD_PAOFF: ctrl_d.clamp_hold = 1'b1;
         default:     ctrl_d = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl <= '0;
      else        ctrl <= ctrl_d;
   end

   // DAC path only with drain enabled and clamp held (R4)
   assert_dac_needs_pa_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.bias_on_dac |-> (ctrl.amp_en && ctrl.clamp_hold));

   // Drain enable rises only with the gate on the clamp (R3)
   assert_pa_rise_on_clamp_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ctrl.amp_en) |-> (!ctrl.bias_on_dac && !$past(ctrl.bias_on_dac)));

   // Drain enable never drops straight from the DAC (R7)
   assert_pa_fall_after_clamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctrl.amp_en) |-> !$past(ctrl.bias_on_dac));

   // No load request while the drain may be live (R2)
   assert_load_excl_pa_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl.load_req |-> !ctrl.amp_en);

   // Rail tracking implies a quiet amplifier (R8)
   assert_track_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.clamp_hold |-> (!ctrl.amp_en && !ctrl.bias_on_dac && !ctrl.load_req));

endmodule

// File: rtl/pa_bias_seq.sv
module pa_bias_seq
   import pa_bias_pkg::*;
#(
   parameter int HOLD_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic supply_ok,
   input  logic load_done,
   input  logic drive_en,
   input  logic alarm,
   output logic load_req,
   output logic clamp_hold,
   output logic bias_on_dac,
   output logic amp_en
);
   generate
      if (HOLD_CYCLES < 1) begin : g_bad_hold
         $error("pa_bias_seq: HOLD_CYCLES must be at least 1 (R11)");
      end
   endgenerate

   seq_state_e state;
   seq_state_e next_state;
   seq_ctrl_t  ctrl;
   logic       hold_done;

   pa_bias_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .supply_ok  (supply_ok),
      .load_done  (load_done),
      .drive_en   (drive_en),
      .alarm      (alarm),
      .hold_done  (hold_done),
      .state      (state),
      .next_state (next_state)
   );

   pa_bias_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (state == ST_SD_CLAMP),
      .done  (hold_done)
   );

   pa_bias_outreg u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .next_state (next_state),
      .ctrl       (ctrl)
   );

   assign load_req    = ctrl.load_req;
   assign clamp_hold  = ctrl.clamp_hold;
   assign bias_on_dac = ctrl.bias_on_dac;
   assign amp_en      = ctrl.amp_en;

   // Alarm pulls the gate off the DAC on the very next edge (R6)
   assert_alarm_to_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm && bias_on_dac) |=> !bias_on_dac);

endmodule

// File: tb/test_pa_bias_seq.sv
`timescale 1ns/100ps
module test_pa_bias_seq;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic supply_ok = 1'b0, load_done = 1'b0, drive_en = 1'b0, alarm = 1'b0;
   logic load_req, clamp_hold, bias_on_dac, amp_en;

   int n_chk  = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   pa_bias_seq #(.HOLD_CYCLES(4)) i_pa_bias_seq (
      .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .load_done(load_done),
      .drive_en(drive_en), .alarm(alarm), .load_req(load_req),
      .clamp_hold(clamp_hold), .bias_on_dac(bias_on_dac), .amp_en(amp_en)
   );

   // {supply_ok, load_done, drive_en, alarm, exp load_req, clamp_hold, bias_on_dac, amp_en}
   localparam int NV = 44;
   localparam logic [7:0] VEC [NV] = '{
      8'b0000_0000, 8'b0010_0000,                              // R1 ramp, R4 early drive ignored
      8'b1000_1100, 8'b1000_1100, 8'b1010_1100,                // R2 load, R4 drive in load ignored
      8'b1100_0100, 8'b1000_0101, 8'b1000_0101,                // R3 done, enable next edge
      8'b1010_0111, 8'b1010_0111, 8'b1000_0101, 8'b1010_0111,  // R4 to DAC, R5 back to clamp
      8'b1011_0101, 8'b1010_0101, 8'b1000_0101, 8'b1000_0101,  // R6 alarm, R7 hold window
      8'b1000_0100, 8'b1000_0000,                              // R7 enable falls, R8 tracking
      8'b1000_0000, 8'b1000_0000, 8'b0000_0000, 8'b1001_0000,  // R9 no exit without fall, alarm blocks
      8'b1000_0000, 8'b1000_1100,                              // R9 ramp then new load
      8'b1101_0100, 8'b1000_0100, 8'b1000_0100, 8'b1000_0100,  // R10 alarm beats done
      8'b1000_0100, 8'b1000_0000,                              // R10 shutdown, no enable
      8'b0000_0000, 8'b1000_0000, 8'b1000_1100, 8'b1100_0100,  // R9 restart
      8'b1000_0101, 8'b1010_0111, 8'b0010_0101,                // R6 supply collapse on DAC
      8'b0010_0101, 8'b0010_0101, 8'b0010_0101, 8'b0010_0100,  // R7 hold, drive ignored
      8'b0010_0000, 8'b1000_0000, 8'b1000_1100                 // R8, R9 low seen during shutdown
   };
   localparam int TAG [NV] = '{
      1, 4, 2, 2, 4, 3, 3, 3, 4, 4, 5, 4, 6, 6, 7, 7, 7, 8, 9, 9, 9, 9,
      9, 9, 10, 10, 10, 10, 10, 10, 9, 9, 9, 3, 3, 4, 6, 7, 7, 7, 7, 8, 9, 9
   };

   task automatic check(input logic [3:0] exp, input int rq, input string what);
      logic [3:0] act;
      act = {load_req, clamp_hold, bias_on_dac, amp_en};
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL R%0d %s: actual %b expected %b", rq, what, act, exp);
      end
   endtask

   task automatic apply(input logic [3:0] ins, input logic [3:0] exp, input int rq);
      @(negedge clk);
      {supply_ok, load_done, drive_en, alarm} = ins;
      @(posedge clk);
      #1;
      check(exp, rq, "vector");
   endtask

   initial begin
      #(200000 * 5);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check(4'b0000, 1, "in reset (R1)");
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk);
      #1;
      check(4'b0000, 1, "after reset (R1)");

      for (int i = 0; i < NV; i++)
         apply(VEC[i][7:4], VEC[i][3:0], TAG[i]);

      // R4: drive_en already high before the enable rises
      apply(4'b1110, 4'b0100, 4);
      apply(4'b1010, 4'b0101, 4);
      apply(4'b1010, 4'b0111, 4);

      // R1: asynchronous reset while on the DAC
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(4'b0000, 1, "async reset from DAC (R1)");
      @(negedge clk);
      {supply_ok, load_done, drive_en, alarm} = 4'b0000;
      rst_n = 1'b1;
      apply(4'b0000, 4'b0000, 1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule